// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block takes one 8-bit character at a time through a valid/ready handshake and sends it on a single output line. The frame always has one low start bit, eight data bits, an optional even-parity bit and one high stop bit. Configuration inputs choose the bit order, whether parity is added, whether the data bits are inverted, and whether bit timing comes from a baud tick or from an external serial clock. In clocked operation, a polarity input picks which clock edge moves the line.

The configuration is captured together with the character when the character is accepted. Later changes to the configuration inputs therefore affect only the next frame. When the stop bit has been held for its full period, the block raises a one-cycle completion pulse and returns to ready. The baud tick and the serial clock come from outside the block.

Top module: `ser_tx_top`

## Requirements
- R1: While reset is high and in the cycle after it, the line `txd` is 1, `tx_ready` is 1 and `tx_done` is 0. A reset in the middle of a frame abandons that frame.
- R2: A character is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until the frame ends. `tx_valid` or `tx_data` activity while busy is ignored and never starts a second frame. Bit strobes while idle leave `txd` at 1.
- R3: After acceptance the line stays 1 until the first bit strobe. Each strobe then puts the next frame bit on `txd` in the cycle after the strobe. The order of frame bits is: start (0), eight data bits, optional parity, stop (1). Between strobes `txd` does not change.
- R4: With `cfg_lsb_first` = 0 the data bits go out from bit 7 down to bit 0. With `cfg_lsb_first` = 1 they go out from bit 0 up to bit 7.
- R5: With `cfg_parity_en` = 1 a parity bit follows the data bits, chosen so that the data bits on the line plus the parity bit hold an even number of ones. With `cfg_parity_en` = 0 the stop bit follows the data directly.
- R6: With `cfg_data_inv` = 1 each data bit on the line is the complement of the character bit, and the parity is computed over the complemented bits. Start and stop bits keep their polarity in both cases.
- R7: In asynchronous mode (`cfg_sync_mode` = 0) a bit strobe is one cycle with `baud_tick` = 1. In synchronous mode (`cfg_sync_mode` = 1) `baud_tick` is ignored. A strobe is then a rising `sclk` edge when `cfg_sclk_pol` = 0 and a falling `sclk` edge when `cfg_sclk_pol` = 1, and the other edge never moves `txd`.
- R8: The strobe that ends the stop-bit period makes `tx_done` 1 for exactly one cycle. `tx_ready` returns to 1 in that same cycle and `txd` is 1.
- R9: All five configuration inputs are sampled when the character is accepted. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block idle and able to take a character |
| cfg_lsb_first | input | 1 | 1 = least significant data bit first |
| cfg_sclk_pol | input | 1 | Synchronous mode: 0 = rising edge moves txd, 1 = falling edge |
| cfg_sync_mode | input | 1 | 0 = baud tick timing, 1 = serial clock timing |
| cfg_parity_en | input | 1 | 1 = append even parity bit |
| cfg_data_inv | input | 1 | 1 = complement the data bits |
| baud_tick | input | 1 | One-cycle bit-period strobe (asynchronous mode) |
| sclk | input | 1 | Serial clock, sampled in the clk domain (synchronous mode) |
| txd | output | 1 | Serial line, idles high |
| tx_done | output | 1 | One-cycle pulse when the stop bit completes |

## Verification
The checks assume that `sclk` is produced in the `clk` domain. Each level must last at least one clock, so that a single registered copy of `sclk` catches every edge. They also assume that `baud_tick` is never high in two consecutive cycles. The stimulus changes `sclk` and `baud_tick` only on falling `clk` edges and holds every level for several cycles. Before a character is offered in synchronous mode, the stimulus parks `sclk` at its inactive level, so a frame always starts from a known clock level. Changes to configuration and `tx_valid` during a frame are applied on purpose, to show that they are ignored.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int CHAR_W  = 8;
    localparam int FRAME_W = CHAR_W + 3;               // start + data + parity + stop
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_SHIFT
    } tx_state_t;

    typedef struct packed {
        logic lsb_first;
        logic sclk_pol;
        logic sync_mode;
        logic parity_en;
        logic data_inv;
    } tx_cfg_t;

    function automatic logic even_par_bit(input logic [CHAR_W-1:0] bits);
        return ^bits;
    endfunction

endpackage

// File: rtl/tx_bit_strobe.sv
module tx_bit_strobe (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  logic sclk_pol,
    input  logic baud_tick,
    input  logic sclk,
    output logic bit_stb
);
    logic sclk_q;
    logic sclk_edge;
    logic sclk_active;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    // An edge whose new level differs from the polarity setting is the active one.
    assign sclk_edge   = sclk ^ sclk_q;
    assign sclk_active = sclk_edge & (sclk ^ sclk_pol);
    assign bit_stb     = sync_mode ? sclk_active : baud_tick;
endmodule

// File: rtl/tx_frame_pack.sv
module tx_frame_pack
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = CHAR_W,
    parameter int FW     = DATA_W + 3,
    parameter int CW     = $clog2(FW + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic              lsb_first,
    input  logic              parity_en,
    input  logic              data_inv,
    output logic [FW-1:0]     frame,
    output logic [CW-1:0]     nbits
);
    logic [DATA_W-1:0] rev;
    logic [DATA_W-1:0] ordered;
    logic [DATA_W-1:0] line_bits;
    logic              par;

    for (genvar g = 0; g < DATA_W; g++) begin : g_rev
        assign rev[g] = data[DATA_W-1-g];
    end

    // Bit 0 of the frame vector leaves first.
    assign ordered   = lsb_first ? data : rev;
    assign line_bits = ordered ^ {DATA_W{data_inv}};
    assign par       = even_par_bit(line_bits);

    always_comb begin
        if (parity_en) begin
            frame = {1'b1, par, line_bits, 1'b0};
            nbits = CW'(FW);
        end else begin
            frame = {1'b1, 1'b1, line_bits, 1'b0};
            nbits = CW'(FW - 1);
        end
    end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import ser_tx_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [FW-1:0] frame_in,
    input  logic [CW-1:0] nbits_in,
    input  logic          sync_in,
    input  logic          pol_in,
    input  logic          bit_stb,
    output logic          sync_q,
    output logic          pol_q,
    output logic          ready,
    output logic          txd,
    output logic          done
);
    tx_state_t     state;
    logic [FW-1:0] shreg;
    logic [CW-1:0] idx;
    logic [CW-1:0] nbits_q;

    assign ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '1;
            idx     <= '0;
            nbits_q <= '0;
            sync_q  <= 1'b0;
            pol_q   <= 1'b0;
            txd     <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        shreg   <= frame_in;
                        nbits_q <= nbits_in;
                        sync_q  <= sync_in;
                        pol_q   <= pol_in;
                        state   <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (bit_stb) begin
                        txd   <= shreg[0];
                        shreg <= {1'b1, shreg[FW-1:1]};
                        idx   <= '0;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (bit_stb) begin
                        if (idx == nbits_q - CW'(1)) begin
                            txd   <= 1'b1;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            txd   <= shreg[0];
                            shreg <= {1'b1, shreg[FW-1:1]};
                            idx   <= idx + CW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = CHAR_W,
    localparam int FW    = DATA_W + 3,
    localparam int CW    = $clog2(FW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              cfg_lsb_first,
    input  logic              cfg_sclk_pol,
    input  logic              cfg_sync_mode,
    input  logic              cfg_parity_en,
    input  logic              cfg_data_inv,
    input  logic              baud_tick,
    input  logic              sclk,
    output logic              txd,
    output logic              tx_done
);
    tx_cfg_t       cfg;
    logic [FW-1:0] frame;
    logic [CW-1:0] nbits;
    logic          sync_q;
    logic          pol_q;
    logic          bit_stb;
    logic          accept;

    assign cfg = '{lsb_first: cfg_lsb_first, sclk_pol: cfg_sclk_pol,
                   sync_mode: cfg_sync_mode, parity_en: cfg_parity_en,
                   data_inv: cfg_data_inv};

    assign accept = tx_valid & tx_ready;

    tx_frame_pack #(.DATA_W(DATA_W), .FW(FW), .CW(CW)) u_pack (
        .data      (tx_data),
        .lsb_first (cfg.lsb_first),
        .parity_en (cfg.parity_en),
        .data_inv  (cfg.data_inv),
        .frame     (frame),
        .nbits     (nbits)
    );

    tx_bit_strobe u_stb (
        .clk       (clk),
        .rst       (rst),
        .sync_mode (sync_q),
        .sclk_pol  (pol_q),
        .baud_tick (baud_tick),
        .sclk      (sclk),
        .bit_stb   (bit_stb)
    );

    tx_serializer #(.FW(FW), .CW(CW)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .frame_in (frame),
        .nbits_in (nbits),
        .sync_in  (cfg.sync_mode),
        .pol_in   (cfg.sclk_pol),
        .bit_stb  (bit_stb),
        .sync_q   (sync_q),
        .pol_q    (pol_q),
        .ready    (tx_ready),
        .txd      (txd),
        .done     (tx_done)
    );
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic tx_done,
    input logic bit_stb
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (txd && tx_ready && !tx_done));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R3
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(txd));

    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    // R8
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R8
    done_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (tx_ready && txd));
endmodule

bind ser_tx_top ser_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .tx_done  (tx_done),
    .bit_stb  (bit_stb)
);

// File: tb/test_ser_tx_top.sv
module test_ser_tx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       cfg_lsb_first = 1'b0;
    logic       cfg_sclk_pol = 1'b0;
    logic       cfg_sync_mode = 1'b0;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_data_inv = 1'b0;
    logic       baud_tick = 1'b0;
    logic       sclk = 1'b0;
    logic       txd;
    logic       tx_done;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ser_tx_top i_ser_tx_top (
        .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .cfg_lsb_first(cfg_lsb_first),
        .cfg_sclk_pol(cfg_sclk_pol), .cfg_sync_mode(cfg_sync_mode),
        .cfg_parity_en(cfg_parity_en), .cfg_data_inv(cfg_data_inv),
        .baud_tick(baud_tick), .sclk(sclk), .txd(txd), .tx_done(tx_done)
    );

    // Stimulus: {lsb_first, sclk_pol, sync_mode, parity_en, data_inv, data}
    localparam logic [12:0] VECS [9] = '{
        {5'b00000, 8'hB4},
        {5'b10000, 8'hB4},
        {5'b00010, 8'h07},
        {5'b10011, 8'h07},
        {5'b00001, 8'h3C},
        {5'b00100, 8'h96},
        {5'b01110, 8'hE1},
        {5'b11111, 8'h5A},
        {5'b10100, 8'h01}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected line bit number i of a frame, derived from the requirements.
    function automatic logic exp_bit(input int i, input logic [7:0] d, input logic [4:0] c);
        logic [7:0] seq;
        for (int k = 0; k < 8; k++)
            seq[k] = (c[4] ? d[k] : d[7-k]) ^ c[0];
        if (i == 0) return 1'b0;
        if (i <= 8) return seq[i-1];
        if (i == 9 && c[1]) return ^seq;
        return 1'b1;
    endfunction

    function automatic string req_of(input int i, input logic [4:0] c);
        if (i == 0 || i == 10 || (i == 9 && !c[1])) return "R3 start/stop";
        if (i == 9) return "R5/R6 parity";
        if (c[0]) return "R6 inverted data";
        return "R4 data order";
    endfunction

    task automatic apply_cfg(input logic [4:0] c);
        {cfg_lsb_first, cfg_sclk_pol, cfg_sync_mode, cfg_parity_en, cfg_data_inv} = c;
    endtask

    // One bit strobe; returns at the falling edge after txd has updated.
    task automatic strobe(input logic [4:0] c);
        @(negedge clk);
        if (c[2]) sclk = ~c[3];
        else      baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    // Gap between strobes: txd must hold, inactive edge and baud ticks included.
    task automatic gap(input logic [4:0] c, input logic v);
        @(negedge clk);
        if (c[2]) sclk = c[3];
        @(negedge clk);
        check(txd == v, "R7 inactive edge holds txd", txd, v);
        if (c[2]) baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        @(negedge clk);
        check(txd == v, c[2] ? "R7 baud tick ignored" : "R3 hold between strobes", txd, v);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [4:0] c, input bit perturb);
        int  n;
        n = c[1] ? 11 : 10;
        apply_cfg(c);
        sclk = c[3];
        repeat (3) @(negedge clk);
        check(tx_ready == 1'b1, "R2 ready when idle", tx_ready, 1);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R2 ready drops after accept", tx_ready, 0);
        check(txd == 1'b1, "R3 line high before first strobe", txd, 1);
        if (perturb) begin
            tx_valid = 1'b1;
            tx_data  = ~d;
            apply_cfg(~c);
        end
        for (int i = 0; i < n; i++) begin
            strobe(c);
            check(txd == exp_bit(i, d, c), perturb ? "R9 config held" : req_of(i, c),
                  txd, exp_bit(i, d, c));
            check(tx_ready == 1'b0 && tx_done == 1'b0, "R2 busy during frame",
                  {tx_ready, tx_done}, 0);
            gap(c, exp_bit(i, d, c));
        end
        tx_valid = 1'b0;
        strobe(c);
        check(tx_done == 1'b1, "R8 done pulse", tx_done, 1);
        check(tx_ready == 1'b1, "R8 ready with done", tx_ready, 1);
        check(txd == 1'b1, "R8 line high at end", txd, 1);
        @(negedge clk);
        check(tx_done == 1'b0, "R8 done lasts one cycle", tx_done, 0);
        if (c[2]) sclk = c[3];
        apply_cfg(c);
        if (perturb) begin
            repeat (3) @(negedge clk);
            check(tx_ready == 1'b1 && txd == 1'b1, "R2 busy-time valid ignored",
                  {tx_ready, txd}, 2'b11);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1 && tx_ready == 1'b1 && tx_done == 1'b0, "R1 reset outputs",
              {txd, tx_ready, tx_done}, 3'b110);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && tx_ready == 1'b1, "R1 after reset", {txd, tx_ready}, 2'b11);

        // R2 strobes while idle do nothing
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && tx_ready == 1'b1, "R2 idle strobe ignored", {txd, tx_ready}, 2'b11);

        foreach (VECS[v]) run_frame(VECS[v][7:0], VECS[v][12:8], 1'b0);

        // R9 / R2: configuration and valid disturbed during frames
        run_frame(8'hC6, 5'b00010, 1'b1);
        run_frame(8'h3A, 5'b01101, 1'b1);

        // R1 reset in mid-frame
        apply_cfg(5'b00000);
        sclk = 1'b0;
        @(negedge clk);
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        strobe(5'b00000);
        check(txd == 1'b0, "R3 start bit", txd, 0);
        rst = 1'b1;
        @(negedge clk);
        check(txd == 1'b1 && tx_ready == 1'b1 && tx_done == 1'b0, "R1 mid-frame reset",
              {txd, tx_ready, tx_done}, 3'b110);
        rst = 1'b0;
        strobe(5'b00000);
        check(txd == 1'b1 && tx_ready == 1'b1, "R1 frame abandoned", {txd, tx_ready}, 2'b11);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule